// File: doc/BRIEF.md
# Buffered Interval Timer

A 16-bit up-counter that produces a periodic interrupt and a square-wave output in interval mode. Software programs a control word (run bit, count-source select, external-event select, mode field) and a compare value through a simple register write port. The value actually compared is held in a separate buffer register. That buffer is loaded from the compare register when counting starts and again after every match. A new compare value written while the timer runs therefore takes effect from the following interval.

The count clock is not a real clock. The block receives a vector of single-cycle enable pulses from an external prescaler, and the select field picks one of them. The external event input can replace that source: it passes through a two-stage synchronizer, and each rising edge gives one count tick. Everything runs on the single system clock.

Top module: `interval_timer_top`

## Requirements
- R1: After synchronous reset, `tmr_out` and `irq_out` are 0, the timer is stopped, and its counter sits at FFFFH.
- R2: While the timer is not running, the counter stays at FFFFH and count ticks have no effect. Clearing the run bit stops counting on the next clock and leaves `tmr_out` at its present level. A later restart behaves as in R3.
- R3: On the first count tick after the timer starts running, the counter goes from FFFFH to 0, `tmr_out` inverts, and the compare register is copied into the buffer. No interrupt is raised on that tick.
- R4: On a count tick where the counter equals the buffer, the counter clears to 0 and `tmr_out` inverts. `irq_out` is high for exactly the one clock cycle after that tick's clock edge.
- R5: Successive matches are (buffer value + 1) count ticks apart. A buffer value of 0 gives a match on every tick.
- R6: When the event-select bit is 0, only `tick_in[sel]` advances the timer, where sel is control bits [3:1]. Pulses on the other `tick_in` lines are ignored.
- R7: When the event-select bit (control bit 4) is 1, `tick_in` is ignored. `evt_in` passes through two flip-flops, and each 0-to-1 transition yields one tick, which takes effect at the third clock edge after `evt_in` rises.
- R8: The mode field (control bits [7:5]) selects interval operation only when it is 000. With any other value the timer behaves as not running.
- R9: After every match the buffer is reloaded from the compare register. A compare write made during an interval does not change that interval's length but sets the next one.
- R10: A write with `wr_en`=1 and `wr_sel`=0 loads control bits [7:0] from `wr_data[7:0]` (bit 0 = run). A write with `wr_sel`=1 loads the compare register from `wr_data`. Either write takes effect at the clock edge where `wr_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Target: 0 = control, 1 = compare |
| wr_data | input | 16 | Write data |
| tick_in | input | 8 | Prescaled single-cycle count enables |
| evt_in | input | 1 | Asynchronous external event input |
| tmr_out | output | 1 | Toggle output |
| irq_out | output | 1 | One-cycle compare-match interrupt pulse |

## Verification
The hardest case to reach is a compare write that lands partway through a running interval. It must leave the current interval at the buffered length and change only the next one. The stimulus reaches it by lowering the compare value after a few ticks of a longer interval, then counting ticks across two matches. A second awkward case is event counting. There the tick appears only after the synchronizer delay, and the stimulus drives `evt_in` high and low for several cycles each while all `tick_in` lines pulse, to show that only the event edges count. A cycle-accurate reference model in the bench predicts both outputs on every cycle.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int CNT_W  = 16;
    localparam int SRC_N  = 8;
    localparam int SEL_W  = $clog2(SRC_N);
    localparam int SYNC_N = 2;

    // control word, bit 0 = run, [3:1] = source select, 4 = event select, [7:5] = mode
    typedef struct packed {
        logic [2:0]       mode;
        logic             evt_sel;
        logic [SEL_W-1:0] src_sel;
        logic             run;
    } ivt_ctl_t;

    localparam int CTL_W = $bits(ivt_ctl_t);

    typedef enum logic {
        REG_CTL = 1'b0,
        REG_CMP = 1'b1
    } ivt_reg_e;

    localparam logic [2:0] MODE_INTERVAL = 3'b000;

    function automatic logic ivt_active(input ivt_ctl_t c);
        return c.run && (c.mode == MODE_INTERVAL);
    endfunction

endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  ivt_reg_e     wr_sel,
    input  logic [W-1:0] wr_data,
    output ivt_ctl_t     ctl_o,
    output logic [W-1:0] cmp_o
);

    ivt_ctl_t     ctl_q;
    logic [W-1:0] cmp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            cmp_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == REG_CTL) ctl_q <= ivt_ctl_t'(wr_data[CTL_W-1:0]);
            else                   cmp_q <= wr_data;
        end
    end

    assign ctl_o = ctl_q;
    assign cmp_o = cmp_q;

    assert_ctl_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == REG_CTL) |=> (ctl_q == $past(wr_data[CTL_W-1:0])));

    assert_cmp_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == REG_CMP) |=> (cmp_q == $past(wr_data)));

endmodule

// File: rtl/ivt_tick_sel.sv
module ivt_tick_sel
    import ivt_pkg::*;
#(
    parameter int N     = SRC_N,
    parameter int DEPTH = SYNC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  ivt_ctl_t     ctl,
    input  logic [N-1:0] tick_in,
    input  logic         evt_in,
    output logic         tick_o
);

    // DEPTH synchronizer stages plus one history stage for edge detection
    logic [DEPTH:0] sh_q;
    logic           evt_edge;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[DEPTH-1:0], evt_in};
    end

    assign evt_edge = sh_q[DEPTH-1] & ~sh_q[DEPTH];
    assign tick_o   = ctl.evt_sel ? evt_edge : tick_in[ctl.src_sel];

    assert_evt_single_R7: assert property (@(posedge clk) disable iff (rst)
        evt_edge |=> !evt_edge);

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
    import ivt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         tick,
    input  logic [W-1:0] cmp,
    output logic         flip_o,
    output logic         irq_o
);

    localparam logic [W-1:0] IDLE_VAL = '1;

    typedef struct packed {
        logic         started;
        logic [W-1:0] cnt;
        logic [W-1:0] buf_v;
    } cnt_state_t;

    cnt_state_t st_q, st_d;
    logic       irq_q, irq_d;
    logic       hit;

    assign hit = st_q.started && (st_q.cnt == st_q.buf_v);

    always_comb begin
        st_d   = st_q;
        irq_d  = 1'b0;
        flip_o = 1'b0;
        if (!active) begin
            st_d.started = 1'b0;
            st_d.cnt     = IDLE_VAL;
        end else if (tick) begin
            if (!st_q.started) begin
                st_d.started = 1'b1;
                st_d.cnt     = '0;
                st_d.buf_v   = cmp;
                flip_o       = 1'b1;
            end else if (hit) begin
                st_d.cnt   = '0;
                st_d.buf_v = cmp;
                flip_o     = 1'b1;
                irq_d      = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '{started: 1'b0, cnt: IDLE_VAL, buf_v: '0};
            irq_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q;

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !active |=> (st_q.cnt == IDLE_VAL && !st_q.started));

    assert_irq_cause_R4: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> ($past(tick) && $past(st_q.started) && st_q.cnt == '0));

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        st_q.started |-> (st_q.cnt <= st_q.buf_v));

    assert_start_load_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.started) |-> (st_q.cnt == '0 && st_q.buf_v == $past(cmp) && !irq_q));

endmodule

// File: rtl/interval_timer_top.sv
module interval_timer_top
    import ivt_pkg::*;
#(
    parameter int W = CNT_W,
    parameter int N = SRC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [N-1:0] tick_in,
    input  logic         evt_in,
    output logic         tmr_out,
    output logic         irq_out
);

    ivt_ctl_t     ctl;
    logic [W-1:0] cmp;
    logic         tick;
    logic         active;
    logic         flip;
    logic         out_q;

    ivt_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (ivt_reg_e'(wr_sel)),
        .wr_data (wr_data),
        .ctl_o   (ctl),
        .cmp_o   (cmp)
    );

    ivt_tick_sel #(.N(N), .DEPTH(SYNC_N)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .tick_in (tick_in),
        .evt_in  (evt_in),
        .tick_o  (tick)
    );

    assign active = ivt_active(ctl);

    ivt_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .tick   (tick),
        .cmp    (cmp),
        .flip_o (flip),
        .irq_o  (irq_out)
    );

    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= out_q ^ flip;
    end

    assign tmr_out = out_q;

    assert_toggle_cause_R3: assert property (@(posedge clk) disable iff (rst)
        (out_q != $past(out_q)) |-> ($past(active) && $past(tick)));

    assert_irq_toggles_R4: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (out_q != $past(out_q)));

    assert_mode_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode != MODE_INTERVAL) |=> $stable(out_q) && !irq_out);

endmodule

// File: tb/tb_interval_timer_top.sv
`timescale 1ns/1ps
module tb_interval_timer_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  tick_in = '0;
    logic        evt_in = 1'b0;
    logic        tmr_out;
    logic        irq_out;

    always #4 clk = ~clk;

    interval_timer_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tick_in(tick_in), .evt_in(evt_in), .tmr_out(tmr_out), .irq_out(irq_out)
    );

    typedef struct {
        logic  out;
        logic  irq;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // reference model state
    logic [7:0]  m_ctl = '0;
    logic [15:0] m_cmp = '0, m_cnt = 16'hFFFF, m_buf = '0;
    logic        m_started = 0, m_out = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0;

    task automatic step(input logic [7:0] tk, input logic ev, input logic we,
                        input logic sel, input logic [15:0] data, input string req);
        logic run, t, flip, irq;
        exp_t e;
        @(posedge clk); #2;
        tick_in = tk; evt_in = ev; wr_en = we; wr_sel = sel; wr_data = data;
        run  = m_ctl[0] && (m_ctl[7:5] == 3'b000);
        t    = m_ctl[4] ? (m_s2 & ~m_s3) : tk[m_ctl[3:1]];
        flip = 0; irq = 0;
        if (!run) begin
            m_cnt = 16'hFFFF; m_started = 0;
        end else if (t) begin
            if (!m_started) begin
                m_cnt = 0; m_started = 1; m_buf = m_cmp; flip = 1;
            end else if (m_cnt == m_buf) begin
                m_cnt = 0; m_buf = m_cmp; flip = 1; irq = 1;
            end else m_cnt = m_cnt + 1;
        end
        m_out = m_out ^ flip;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = ev;
        if (we) begin
            if (sel) m_cmp = data;
            else     m_ctl = data[7:0];
        end
        e.out = m_out; e.irq = irq; e.req = req;
        q.push_back(e);
    endtask

    task automatic wr(input logic sel, input logic [15:0] data, input string req);
        step('0, 0, 1, sel, data, req);
    endtask

    task automatic ticks(input int n, input int idx, input int gap, input string req);
        for (int i = 0; i < n; i++) begin
            step(8'(1 << idx), 0, 0, 0, '0, req);
            for (int g = 0; g < gap; g++) step('0, 0, 0, 0, '0, req);
        end
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            n_vec++;
            if (tmr_out !== e.out || irq_out !== e.irq) begin
                n_bad++;
                $display("FAIL %s: tmr_out=%b irq_out=%b expected tmr_out=%b irq_out=%b",
                         e.req, tmr_out, irq_out, e.out, e.irq);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(posedge clk); #3;
        // R1: reset state
        n_vec++;
        if (tmr_out !== 1'b0 || irq_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: tmr_out=%b irq_out=%b expected 0 0", tmr_out, irq_out);
        end
        // R1: ticks do nothing while stopped
        ticks(4, 0, 0, "R1");
        // R10 + R3/R4/R5: compare 3, source 2, run
        wr(1, 16'd3, "R10");
        wr(0, 16'h0005, "R10");
        ticks(13, 2, 0, "R5");
        ticks(6, 2, 2, "R4");
        // R6: other sources ignored
        ticks(6, 5, 0, "R6");
        ticks(3, 0, 1, "R6");
        // R9: lower compare mid-interval
        ticks(1, 2, 0, "R9");
        wr(1, 16'd1, "R9");
        ticks(12, 2, 0, "R9");
        // R2: stop, ticks ignored, restart
        wr(0, 16'h0004, "R2");
        ticks(5, 2, 0, "R2");
        wr(0, 16'h0005, "R2");
        ticks(5, 2, 0, "R3");
        // R5: compare 0 -> match every tick
        wr(1, 16'd0, "R5");
        ticks(8, 2, 0, "R5");
        // R7: event count with all tick lines pulsing
        wr(1, 16'd2, "R7");
        wr(0, 16'h0010, "R7");
        wr(0, 16'h0011, "R7");
        for (int i = 0; i < 10; i++) begin
            for (int k = 0; k < 3; k++) step(8'hFF, 1, 0, 0, '0, "R7");
            for (int k = 0; k < 3; k++) step(8'hFF, 0, 0, 0, '0, "R7");
        end
        // R8: non-interval mode stays idle
        wr(0, 16'h0061, "R8");
        ticks(6, 0, 0, "R8");
        wr(0, 16'h0001, "R8");
        ticks(7, 0, 0, "R8");
        repeat (4) step('0, 0, 0, 0, '0, "R4");
        repeat (3) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule